// File: doc/BRIEF.md
# Masked Vector Lane Write-Back Unit

This unit produces the final value written to a 512-bit vector destination after a computation. It receives the freshly computed result and the old destination contents. It also receives an element-width code, the index of a write-mask register and a zero/merge control. Each element of the vector is either taken from the new result or treated as unselected. In zeroing mode an unselected element is cleared. In merging mode it keeps its old contents.

The unit holds its own file of eight 64-bit mask registers, which a separate port writes. The selected mask register supplies one bit per element. The element width decides how many bytes each mask bit covers, and mask bits past the last element are ignored. Mask index 0 does not select a real mask: it means every element is written, and register 0 keeps its stored value. A pure bitwise operation still supplies an element width, and that width only controls how the mask is applied. The merged vector is registered, and a one-cycle valid pulse marks it.

Top module: `vmask_wb`

## Requirements
- R1: After reset `out_valid` is 0, `out_data` is all zeros, and every mask register holds 0.
- R2: A cycle with `in_valid` high gives `out_valid` high in the next cycle, for one cycle only. When `in_valid` is low, `out_valid` is low in the next cycle and `out_data` keeps its value.
- R3: The `in_ewidth` codes are 0 for 8-bit, 1 for 16-bit, 2 for 32-bit and 3 for 64-bit elements. Element i occupies bits [i*W +: W], with element 0 in the least significant bits. Mask bit i controls element i.
- R4: An element whose mask bit is 1 takes the value of `in_result`.
- R5: When `in_zeroing` is 1, an element whose mask bit is 0 is written as zero.
- R6: When `in_zeroing` is 0, an element whose mask bit is 0 takes the value of `in_old`.
- R7: When `in_mask_idx` is 0, every element takes `in_result`, whatever mask register 0 holds.
- R8: A mask register write is used by operations from the next cycle on. An operation in the same cycle as a write to its mask register uses the previous contents.
- R9: Mask bits at or above the element count are ignored: bits 16 to 63 for 32-bit elements and bits 8 to 63 for 64-bit elements.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mk_wr_en | input | 1 | Mask register write enable |
| mk_wr_idx | input | 3 | Mask register to write |
| mk_wr_data | input | 64 | Value to store |
| in_valid | input | 1 | Operation present this cycle |
| in_result | input | 512 | Newly computed vector |
| in_old | input | 512 | Previous destination contents |
| in_ewidth | input | 2 | Element width code |
| in_mask_idx | input | 3 | Write-mask register index, 0 means unmasked |
| in_zeroing | input | 1 | 1 clears unselected elements, 0 merges them |
| out_valid | output | 1 | Write-back value present |
| out_data | output | 512 | Masked write-back value |

## Verification
The merged vector and its valid pulse are due one clock edge after the operation is presented. The bench drives each operation on a falling edge and reads `out_valid` and `out_data` on the following falling edge. It reads them again one falling edge later to confirm that the pulse has ended and the data is held. A mask register write counts from the edge that stores it. The bench therefore drives a write and a use of the same register in one cycle and expects the old mask, then uses the register again in the next cycle and expects the new mask.

// File: rtl/vmask_pkg.sv
package vmask_pkg;

   // element width code, as applied to the mask expansion
   typedef enum logic [1:0] {
      EW_B8  = 2'd0,
      EW_B16 = 2'd1,
      EW_B32 = 2'd2,
      EW_B64 = 2'd3
   } ewidth_e;

endpackage

// File: rtl/vmask_regfile.sv
module vmask_regfile #(
   parameter int NUM_MREG = 8,
   parameter int MASK_W   = 64,
   localparam int IDX_W   = $clog2(NUM_MREG)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [MASK_W-1:0] wr_data,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [MASK_W-1:0] rd_data
);

   logic [MASK_W-1:0] regs [NUM_MREG];

   if ((1 << IDX_W) != NUM_MREG) begin : g_chk_pow2
      $error("NUM_MREG must be a power of two");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int r = 0; r < NUM_MREG; r++) regs[r] <= '0;
      end else if (wr_en) begin
         regs[wr_idx] <= wr_data;
      end
   end

   assign rd_data = regs[rd_idx];

   AST_MREG_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> regs[$past(wr_idx)] == $past(wr_data)); // R8

endmodule

// File: rtl/vmask_expand.sv
module vmask_expand
   import vmask_pkg::*;
#(
   parameter int VEC_W        = 512,
   parameter int MASK_W       = 64,
   parameter int IDX_W        = 3,
   parameter bit UNMASK_IDX0  = 1'b1,
   localparam int NBYTES      = VEC_W / 8
) (
   input  ewidth_e           ewidth,
   input  logic [IDX_W-1:0]  idx,
   input  logic [MASK_W-1:0] mask_val,
   output logic [NBYTES-1:0] byte_en
);

   if (MASK_W < NBYTES) begin : g_chk_mw
      $error("MASK_W must cover one bit per byte lane");
   end

   logic [NBYTES-1:0] sel;
   logic              bypass;

   if (UNMASK_IDX0) begin : g_idx0_bypass
      assign bypass = (idx == '0);
   end else begin : g_idx0_real
      assign bypass = 1'b0;
   end

   for (genvar b = 0; b < NBYTES; b++) begin : g_lane
      always_comb begin
         unique case (ewidth)
            EW_B8:   sel[b] = mask_val[b];
            EW_B16:  sel[b] = mask_val[b/2];
            EW_B32:  sel[b] = mask_val[b/4];
            default: sel[b] = mask_val[b/8];
         endcase
      end
      assign byte_en[b] = bypass | sel[b];
   end

endmodule

// File: rtl/vmask_merge.sv
module vmask_merge #(
   parameter int VEC_W   = 512,
   localparam int NBYTES = VEC_W / 8
) (
   input  logic [VEC_W-1:0]  result,
   input  logic [VEC_W-1:0]  old,
   input  logic [NBYTES-1:0] byte_en,
   input  logic              zeroing,
   output logic [VEC_W-1:0]  data
);

   if (VEC_W % 8 != 0) begin : g_chk_vw
      $error("VEC_W must be a whole number of bytes");
   end

   for (genvar b = 0; b < NBYTES; b++) begin : g_byte
      logic [7:0] keep;
      assign keep = zeroing ? 8'h00 : old[b*8 +: 8];
      assign data[b*8 +: 8] = byte_en[b] ? result[b*8 +: 8] : keep;
   end

endmodule

// File: rtl/vmask_wb.sv
module vmask_wb
   import vmask_pkg::*;
#(
   parameter int VEC_W    = 512,
   parameter int MASK_W   = 64,
   parameter int NUM_MREG = 8,
   localparam int IDX_W   = $clog2(NUM_MREG),
   localparam int NBYTES  = VEC_W / 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mk_wr_en,
   input  logic [IDX_W-1:0]  mk_wr_idx,
   input  logic [MASK_W-1:0] mk_wr_data,
   input  logic              in_valid,
   input  logic [VEC_W-1:0]  in_result,
   input  logic [VEC_W-1:0]  in_old,
   input  logic [1:0]        in_ewidth,
   input  logic [IDX_W-1:0]  in_mask_idx,
   input  logic              in_zeroing,
   output logic              out_valid,
   output logic [VEC_W-1:0]  out_data
);

   logic [MASK_W-1:0] mask_rd;
   logic [NBYTES-1:0] byte_en;
   logic [VEC_W-1:0]  merged;

   vmask_regfile #(.NUM_MREG(NUM_MREG), .MASK_W(MASK_W)) u_mregs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (mk_wr_en),
      .wr_idx  (mk_wr_idx),
      .wr_data (mk_wr_data),
      .rd_idx  (in_mask_idx),
      .rd_data (mask_rd)
   );

   vmask_expand #(.VEC_W(VEC_W), .MASK_W(MASK_W), .IDX_W(IDX_W)) u_expand (
      .ewidth   (ewidth_e'(in_ewidth)),
      .idx      (in_mask_idx),
      .mask_val (mask_rd),
      .byte_en  (byte_en)
   );

   vmask_merge #(.VEC_W(VEC_W)) u_merge (
      .result  (in_result),
      .old     (in_old),
      .byte_en (byte_en),
      .zeroing (in_zeroing),
      .data    (merged)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) out_data <= merged;
      end
   end

   AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid); // R2
   AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid); // R2
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(out_data)); // R2
   AST_IDX0_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_mask_idx == '0) |=> out_data == $past(in_result)); // R7
   AST_ZERO_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_zeroing) |=> (out_data & ~$past(in_result)) == '0); // R5
   AST_MERGE_SRC: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !in_zeroing) |=>
         ((out_data ^ $past(in_result)) & (out_data ^ $past(in_old))) == '0); // R6

endmodule

// File: tb/vmask_wb_tb.sv
module vmask_wb_tb;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         mk_wr_en = 1'b0;
   logic [2:0]   mk_wr_idx = '0;
   logic [63:0]  mk_wr_data = '0;
   logic         in_valid = 1'b0;
   logic [511:0] in_result = '0;
   logic [511:0] in_old = '0;
   logic [1:0]   in_ewidth = '0;
   logic [2:0]   in_mask_idx = '0;
   logic         in_zeroing = 1'b0;
   logic         out_valid;
   logic [511:0] out_data;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;
   logic [63:0] shadow [8];

   always #5 clk = ~clk;

   vmask_wb u_dut (
      .clk(clk), .rst_n(rst_n),
      .mk_wr_en(mk_wr_en), .mk_wr_idx(mk_wr_idx), .mk_wr_data(mk_wr_data),
      .in_valid(in_valid), .in_result(in_result), .in_old(in_old),
      .in_ewidth(in_ewidth), .in_mask_idx(in_mask_idx), .in_zeroing(in_zeroing),
      .out_valid(out_valid), .out_data(out_data)
   );

   function automatic logic [511:0] pat(input int seed);
      logic [511:0] v;
      for (int w = 0; w < 16; w++)
         v[w*32 +: 32] = (seed * 32'h9E37_79B9) ^ (w * 32'h0101_0101 + w + seed);
      return v;
   endfunction

   // element-wise model, written from the requirements
   function automatic logic [511:0] model(input logic [511:0] res, input logic [511:0] old,
                                          input int ew, input logic [63:0] m,
                                          input bit unmasked, input bit zero);
      logic [511:0] o;
      int ebits = 8 << ew;
      for (int k = 0; k < 512; k++) begin
         int e = k / ebits;
         if (unmasked || m[e]) o[k] = res[k];
         else                  o[k] = zero ? 1'b0 : old[k];
      end
      return o;
   endfunction

   task automatic chk1(input string tag, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%b expected=%b", tag, act, exp);
      end
   endtask

   task automatic chkv(input string tag, input logic [511:0] act, input logic [511:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr_mask(input int idx, input logic [63:0] val);
      mk_wr_en = 1'b1; mk_wr_idx = 3'(idx); mk_wr_data = val;
      @(negedge clk);
      mk_wr_en = 1'b0;
      shadow[idx] = val;
   endtask

   // one operation, optionally with a mask write in the same cycle
   task automatic op(input string tag, input int ew, input int idx, input bit zero,
                     input int seed, input bit do_wr, input logic [63:0] wval);
      logic [511:0] exp;
      in_valid = 1'b1; in_result = pat(seed); in_old = pat(seed + 77);
      in_ewidth = 2'(ew); in_mask_idx = 3'(idx); in_zeroing = zero;
      exp = model(in_result, in_old, ew, shadow[idx], idx == 0, zero);
      if (do_wr) begin
         mk_wr_en = 1'b1; mk_wr_idx = 3'(idx); mk_wr_data = wval;
      end
      @(negedge clk);
      in_valid = 1'b0; mk_wr_en = 1'b0;
      if (do_wr) shadow[idx] = wval;
      chk1({tag, " valid"}, out_valid, 1'b1);
      chkv({tag, " data"}, out_data, exp);
   endtask

   task automatic t_reset;
      chk1("R1 out_valid at reset", out_valid, 1'b0);
      chkv("R1 out_data at reset", out_data, '0);
      op("R1 untouched mask reg 5 is zero", 0, 5, 1'b1, 3, 1'b0, '0);
   endtask

   task automatic t_widths;
      wr_mask(1, 64'hA5C3_0F96_1234_5E78);
      for (int ew = 0; ew < 4; ew++) begin
         op($sformatf("R3 R4 R5 zeroing ew=%0d", ew), ew, 1, 1'b1, 10 + ew, 1'b0, '0);
         op($sformatf("R3 R4 R6 merging ew=%0d", ew), ew, 1, 1'b0, 20 + ew, 1'b0, '0);
      end
      wr_mask(4, 64'h0000_0000_0000_0001);
      op("R3 element 0 in low bits ew=3", 3, 4, 1'b1, 31, 1'b0, '0);
   endtask

   task automatic t_high_ignored;
      wr_mask(2, 64'hFFFF_FFFF_FFFF_0000);
      op("R9 32-bit ignores bits 16..63", 2, 2, 1'b1, 40, 1'b0, '0);
      chkv("R9 32-bit all zero", out_data, '0);
      wr_mask(6, 64'hFFFF_FFFF_FFFF_FF00);
      op("R9 64-bit ignores bits 8..63 merge", 3, 6, 1'b0, 41, 1'b0, '0);
      chkv("R9 64-bit all old", out_data, pat(41 + 77));
   endtask

   task automatic t_idx0;
      wr_mask(0, 64'h0);
      op("R7 index 0 unmasked zeroing", 0, 0, 1'b1, 50, 1'b0, '0);
      chkv("R7 equals result", out_data, pat(50));
      op("R7 index 0 unmasked merging ew=2", 2, 0, 1'b0, 51, 1'b0, '0);
   endtask

   task automatic t_same_cycle;
      wr_mask(3, 64'h0000_0000_0000_00F0);
      op("R8 same-cycle write uses old mask", 0, 3, 1'b1, 60, 1'b1, 64'h0F0F_0F0F_0F0F_0F0F);
      op("R8 next cycle uses new mask", 0, 3, 1'b1, 61, 1'b0, '0);
   endtask

   task automatic t_hold;
      logic [511:0] held;
      op("R2 op before idle", 1, 1, 1'b0, 70, 1'b0, '0);
      held = out_data;
      in_result = pat(99); in_old = pat(98);
      @(negedge clk);
      chk1("R2 valid drops after one cycle", out_valid, 1'b0);
      chkv("R2 data held while idle", out_data, held);
      @(negedge clk);
      chkv("R2 data still held", out_data, held);
      op("R2 back-to-back first", 0, 1, 1'b1, 71, 1'b0, '0);
      op("R2 back-to-back second", 2, 1, 1'b0, 72, 1'b0, '0);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      for (int r = 0; r < 8; r++) shadow[r] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_widths;
      t_high_ignored;
      t_idx0;
      t_same_cycle;
      t_hold;
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule